// File: doc/BRIEF.md
# Alternating dual-modulus counter

This block is a synchronous counter whose wrap point changes from one cycle of counting to the next. It first steps through ten states, 0 up to 9. It then steps through three states, 0 up to 2. After that it starts the ten-state run again, and the two runs keep alternating for as long as counting is enabled. A one-bit phase register acts as a mod-2 counter and records which of the two runs is active. A single shared 4-bit count register holds the position within the run. The phase decides which final value is allowed to end the current run.

The block is meant for places that need a repeating pattern of two sub-cycle lengths. One example is a sequence of memory accesses in a fixed order. A count enable lets the sequence advance only on qualifying cycles. A one-cycle terminal pulse marks the last value of each run, so surrounding logic can react when a run finishes.

Top module: `altmod_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is `count` = 0 and `phase` = 0, where phase 0 selects the ten-state run.
- R2: In phase 0 with `en` high, the count advances 0,1,…,9. From 9 it returns to 0.
- R3: In phase 1 with `en` high, the count advances 0,1,2. From 2 it returns to 0. Bits 3:2 of `count` stay 0 throughout phase 1.
- R4: `phase` inverts only on an edge where `en` is high and the count equals the final value of the active run: 9 in phase 0, 2 in phase 1. On every other edge `phase` keeps its value.
- R5: The final value of the inactive run has no effect. For example, a count of 2 in phase 0 with `en` high advances to 3, and `phase` stays 0.
- R6: On the edge where the active run ends, `count` returns to 0 and `phase` inverts. Both happen on that same edge.
- R7: With `en` low at an edge, `count` and `phase` both hold their values.
- R8: `term` is 1 exactly when `en` is 1 and `count` equals the final value of the active run. Otherwise it is 0. `term` is combinational from the current state and `en`.
- R9: Starting from `count` 0 in phase 0, thirteen enabled edges bring the state back to `count` 0 in phase 0. Along the way `term` pulses exactly twice, and `phase` becomes 1 after the tenth enabled edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; when low, the state holds |
| count | output | 4 | Position within the active run |
| phase | output | 1 | 0 = ten-state run, 1 = three-state run |
| term | output | 1 | High on the last enabled cycle of a run |

## Verification
A wrong phase bit shows up on the `phase` port at once. It also shows within at most ten enabled cycles, because the count wraps at the wrong value or runs past 2 with its upper bits set. A missing mask on the inactive final value makes the count drop to 0 and `phase` invert early, at a count of 2 in phase 0. That happens within three enabled cycles of any run start. A stuck or mistimed `term` differs from the expected pulse in the very cycle the state reaches a final value. For that reason the bench compares every port after every edge against an arithmetic model. The model is driven through full runs, interleaved enable gaps and a reset in the middle of a run.

// File: rtl/altmod_pkg.sv
package altmod_pkg;

  // Lengths of the two alternating runs
  parameter int MOD_LONG  = 10;
  parameter int MOD_SHORT = 3;

  localparam int CNT_W = (MOD_LONG > MOD_SHORT) ? $clog2(MOD_LONG) : $clog2(MOD_SHORT);

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic {
    PH_LONG  = 1'b0,
    PH_SHORT = 1'b1
  } phase_t;

  // Final value of the run selected by a phase
  function automatic cnt_t last_of(input phase_t ph);
    return (ph == PH_SHORT) ? cnt_t'(MOD_SHORT - 1) : cnt_t'(MOD_LONG - 1);
  endfunction

  // Successor within a run (no wrap)
  function automatic cnt_t bump(input cnt_t c);
    return c + cnt_t'(1);
  endfunction

endpackage

// File: rtl/altmod_tc.sv
module altmod_tc
  import altmod_pkg::*;
(
  input  logic   en,
  input  cnt_t   count,
  input  phase_t phase,
  output logic   hit_long,
  output logic   hit_short,
  output logic   term
);

  logic hit_sel;

  // Raw final-value detectors, one per run
  assign hit_long  = (count == last_of(PH_LONG));
  assign hit_short = (count == last_of(PH_SHORT));

  // 2:1 steering by phase masks the inactive detector
  always_comb begin
    unique case (phase)
      PH_SHORT: hit_sel = hit_short;
      default:  hit_sel = hit_long;
    endcase
  end

  assign term = en & hit_sel;

endmodule

// File: rtl/altmod_inner.sv
module altmod_inner
  import altmod_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic wrap,
  output cnt_t count
);

  cnt_t count_nx;

  always_comb begin
    count_nx = count;
    if (en) count_nx = wrap ? '0 : bump(count);
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count_nx;
  end

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count));

  // R6
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (en && wrap) |=> (count == '0));

endmodule

// File: rtl/altmod_phase.sv
module altmod_phase
  import altmod_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   flip,
  output phase_t phase
);

  always_ff @(posedge clk) begin
    if (rst)       phase <= PH_LONG;
    else if (flip) phase <= (phase == PH_LONG) ? PH_SHORT : PH_LONG;
  end

  // R4
  phase_steady_chk: assert property (@(posedge clk) disable iff (rst)
    !flip |=> $stable(phase));

  // R4
  phase_flip_chk: assert property (@(posedge clk) disable iff (rst)
    flip |=> (phase != $past(phase)));

endmodule

// File: rtl/altmod_counter.sv
module altmod_counter
  import altmod_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [CNT_W-1:0] count,
  output logic             phase,
  output logic             term
);

  cnt_t   cnt_q;
  phase_t ph_q;
  logic   hit_long;
  logic   hit_short;
  logic   run_done;

  altmod_tc u_tc (
    .en        (en),
    .count     (cnt_q),
    .phase     (ph_q),
    .hit_long  (hit_long),
    .hit_short (hit_short),
    .term      (run_done)
  );

  altmod_inner u_inner (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .wrap  (run_done),
    .count (cnt_q)
  );

  altmod_phase u_phase (
    .clk   (clk),
    .rst   (rst),
    .flip  (run_done),
    .phase (ph_q)
  );

  assign count = cnt_q;
  assign phase = ph_q;
  assign term  = run_done;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (count == '0 && phase == PH_LONG));

  // R2
  long_range_chk: assert property (@(posedge clk) disable iff (rst)
    count <= cnt_t'(MOD_LONG - 1));

  // R3
  short_range_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SHORT) |-> (count <= cnt_t'(MOD_SHORT - 1)));

  // R5
  masked_short_chk: assert property (@(posedge clk) disable iff (rst)
    (en && phase == PH_LONG && hit_short) |=> (phase == PH_LONG && count == cnt_t'(MOD_SHORT)));

  // R8
  term_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    term |-> (en && (hit_long || hit_short)));

endmodule

// File: tb/altmod_counter_tb.sv
module altmod_counter_tb;

  localparam int CLK_P   = 10;
  localparam int LONG_N  = 10;
  localparam int SHORT_N = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [3:0] count;
  logic       phase;
  logic       term;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_cnt = 0;
  int exp_ph  = 0;
  int terms_seen = 0;

  always #(CLK_P/2) clk = ~clk;

  altmod_counter u_dut (
    .clk(clk), .rst(rst), .en(en),
    .count(count), .phase(phase), .term(term)
  );

  function automatic int fin(input int ph);
    return (ph == 1) ? SHORT_N - 1 : LONG_N - 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; ends at the next negedge
  task automatic step(input bit en_v);
    int old_c, old_p;
    bit t;
    en = en_v;
    #1;
    t = en_v && (exp_cnt == fin(exp_ph));
    chk("R8 term", int'(term), int'(t));
    if (t) terms_seen++;
    old_c = exp_cnt; old_p = exp_ph;
    if (en_v) begin
      if (t) begin exp_cnt = 0; exp_ph = 1 - exp_ph; end
      else exp_cnt = exp_cnt + 1;
    end
    @(negedge clk);
    if (!en_v) begin
      chk("R7 count hold", int'(count), old_c);
      chk("R7 phase hold", int'(phase), old_p);
    end else if (t) begin
      chk("R6 wrap count", int'(count), 0);
      chk("R6 wrap phase", int'(phase), 1 - old_p);
    end else if (old_p == 0 && old_c == SHORT_N - 1) begin
      chk("R5 masked count", int'(count), SHORT_N);
      chk("R5 masked phase", int'(phase), 0);
    end else begin
      chk(old_p == 1 ? "R3 count" : "R2 count", int'(count), exp_cnt);
      chk("R4 phase", int'(phase), exp_ph);
    end
    if (exp_ph == 1) chk("R3 upper bits", int'(count[3:2]), 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    en  = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_cnt = 0; exp_ph = 0;
    chk("R1 count", int'(count), 0);
    chk("R1 phase", int'(phase), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R9: one full period from the reset state
    terms_seen = 0;
    for (int i = 0; i < LONG_N + SHORT_N; i++) begin
      step(1'b1);
      if (i == LONG_N - 1) chk("R9 phase after long run", int'(phase), 1);
    end
    chk("R9 count back to 0", int'(count), 0);
    chk("R9 phase back to 0", int'(phase), 0);
    chk("R9 term pulses", terms_seen, 2);

    // Continuous counting over several periods
    for (int i = 0; i < 4 * (LONG_N + SHORT_N); i++) step(1'b1);

    // Enable gaps in several patterns
    for (int i = 0; i < 90; i++) step((i % 3) != 0);
    for (int i = 0; i < 90; i++) step((i % 5) < 2);
    for (int i = 0; i < 40; i++) step(i[0]);

    // Reset in the middle of the short run
    while (exp_ph != 1 || exp_cnt != 1) step(1'b1);
    do_reset();
    for (int i = 0; i < 30; i++) step(1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule